// File: doc/BRIEF.md
# Two-way set-associative data cache with virtual indexing and physical tags

This controller sits between a load/store unit and a next-level memory. It holds recently used 32-byte lines in two ways per set. A request carries only the untranslated low part of the address (the page offset). The set index is taken from that part, so the array lookup starts at once. The page frame number comes from a separate translation port in the same cycle as the request. It is registered and compared against the stored physical tags in the following cycle.

Every access also carries a page attribute bit that selects the store policy. In write-through mode a store hit updates the line and forwards the word to memory, and the line never becomes dirty. In write-back mode a store hit only marks the line dirty. Any miss allocates a line. If the victim is dirty it is first written back as four 64-bit beats. The line is then refilled as four beats in word order, and the stalled access is replayed. Each set has one LRU bit that names its victim way.

Top module: `vipt_dcache`

## Requirements
- R1: A load that hits raises `resp_valid` with the stored word in the cycle after the request is accepted, and it makes no memory request.
- R2: The set is taken from `req_voff[IDX_W+4:5]` and the word within the line from `req_voff[4:3]`. The tag is the physical address `{xl_pfn, req_voff}` above bit IDX_W+4, so the same offset in a different frame misses.
- R3: `xl_pfn` is sampled together with the accepted request, and the data returned comes from that physical frame.
- R4: A write-back store (`req_wthru`=0) that hits writes nothing to memory and marks the line dirty. When a dirty line is evicted, its four words go out at its old physical line address in word order 0..3, and all four are written before the refill read is issued.
- R5: A write-through store (`req_wthru`=1) that hits updates the line and issues exactly one memory write of the word at its physical byte address `{xl_pfn, req_voff}`. Such a store never makes a line dirty, so a later eviction of that line writes nothing.
- R6: Each set keeps one LRU bit, and a hit in one way makes the other way the next victim.
- R7: A miss issues one refill read at the physical line address (low 5 bits zero). It accepts four fill beats for words 0..3 and then replays the access: a load returns the refilled word, and a store merges into the new line.
- R8: Evicting a clean or invalid victim produces no memory write.
- R9: While `mem_wr_valid` is high and `mem_wr_ready` is low, `mem_wr_addr` and `mem_wr_data` hold their values in the next cycle.
- R10: After reset every line is invalid, `req_ready` is high, and no memory request is active.
- R11: The controller takes one request at a time. `req_ready` stays low from acceptance until the response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | CPU request present |
| req_ready | output | 1 | Controller idle, request taken this cycle |
| req_write | input | 1 | 1 = store, 0 = load |
| req_wthru | input | 1 | Page attribute: 1 = write-through, 0 = write-back |
| req_voff | input | PAGE_BITS | Untranslated page-offset address bits |
| req_wdata | input | 64 | Store data |
| xl_pfn | input | PFN_W | Translated page frame number for the request |
| resp_valid | output | 1 | Access complete (one-cycle pulse) |
| resp_rdata | output | 64 | Load data |
| mem_rd_valid | output | 1 | Line refill request |
| mem_rd_ready | input | 1 | Refill request accepted |
| mem_rd_addr | output | PFN_W+PAGE_BITS | Physical line address of the refill |
| mem_fill_valid | input | 1 | Refill beat present |
| mem_fill_data | input | 64 | Refill beat data, words in order 0..3 |
| mem_wr_valid | output | 1 | Word write (writeback beat or write-through word) |
| mem_wr_ready | input | 1 | Word write accepted |
| mem_wr_addr | output | PFN_W+PAGE_BITS | Physical byte address of the word |
| mem_wr_data | output | 64 | Word write data |

## Verification
The bench builds the controller with SETS=4, PFN_W=3 and PAGE_BITS=12. With only four sets and eight frames, random traffic keeps hitting the same sets with different tags. That forces frequent evictions, dirty writebacks and LRU decisions in a short run, and the whole 32 KB physical space fits in a small bench memory. Memory handshakes stall at random, which exercises the hold behaviour of the write port and the gaps between fill beats.

// File: rtl/vipt_dcache.sv
module vipt_dcache #(
  parameter int SETS      = 128,
  parameter int PFN_W     = 20,
  parameter int PAGE_BITS = 12
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       req_valid,
  output logic                       req_ready,
  input  logic                       req_write,
  input  logic                       req_wthru,
  input  logic [PAGE_BITS-1:0]       req_voff,
  input  logic [63:0]                req_wdata,
  input  logic [PFN_W-1:0]           xl_pfn,
  output logic                       resp_valid,
  output logic [63:0]                resp_rdata,
  output logic                       mem_rd_valid,
  input  logic                       mem_rd_ready,
  output logic [PFN_W+PAGE_BITS-1:0] mem_rd_addr,
  input  logic                       mem_fill_valid,
  input  logic [63:0]                mem_fill_data,
  output logic                       mem_wr_valid,
  input  logic                       mem_wr_ready,
  output logic [PFN_W+PAGE_BITS-1:0] mem_wr_addr,
  output logic [63:0]                mem_wr_data
);
  localparam int OFF   = 5;
  localparam int IDX_W = $clog2(SETS);
  localparam int PA_W  = PFN_W + PAGE_BITS;
  localparam int TAG_W = PA_W - OFF - IDX_W;

  initial begin
    if (OFF + IDX_W > PAGE_BITS) $error("index bits exceed page offset");
  end

  typedef enum logic [2:0] {S_IDLE, S_LOOK, S_WB, S_RDREQ, S_FILL, S_WT} st_t;
  st_t st;

  logic [PAGE_BITS-1:0] r_off;
  logic [PFN_W-1:0]     r_pfn;
  logic                 r_we, r_wt;
  logic [63:0]          r_wd;
  logic [1:0]           beat;
  logic                 vway;

  logic [TAG_W-1:0] tag_q [2][SETS];
  logic [63:0]      dat_q [2][SETS*4];
  logic [SETS-1:0]  val_q [2];
  logic [SETS-1:0]  dty_q [2];
  logic [SETS-1:0]  lru_q;

  wire [PA_W-1:0]  r_pa = {r_pfn, r_off};
  wire [IDX_W-1:0] idx  = r_off[OFF+IDX_W-1:OFF];
  wire [1:0]       wsel = r_off[4:3];
  wire [TAG_W-1:0] ptag = r_pa[PA_W-1:OFF+IDX_W];
  logic unused_pa_low;
  assign unused_pa_low = ^r_pa[OFF+IDX_W-1:0];

  wire hit0 = val_q[0][idx] && (tag_q[0][idx] == ptag);
  wire hit1 = val_q[1][idx] && (tag_q[1][idx] == ptag);
  wire hit  = hit0 || hit1;
  wire hway = hit1;
  wire look_hit  = (st == S_LOOK) && hit;
  wire look_miss = (st == S_LOOK) && !hit;
  wire lway   = lru_q[idx];
  wire vdirty = val_q[lway][idx] && dty_q[lway][idx];

  assign req_ready    = (st == S_IDLE);
  assign mem_rd_valid = (st == S_RDREQ);
  assign mem_rd_addr  = {ptag, idx, 5'b0};
  assign mem_wr_valid = (st == S_WB) || (st == S_WT);
  assign mem_wr_addr  = (st == S_WB) ? {tag_q[vway][idx], idx, beat, 3'b0}
                                     : {ptag, idx, wsel, 3'b0};
  assign mem_wr_data  = (st == S_WB) ? dat_q[vway][{idx, beat}] : r_wd;
  assign resp_valid   = (look_hit && !(r_we && r_wt)) || ((st == S_WT) && mem_wr_ready);
  assign resp_rdata   = dat_q[hway][{idx, wsel}];

  wire              fill_go = (st == S_FILL) && mem_fill_valid;
  wire              dat_we  = (look_hit && r_we) || fill_go;
  wire              dat_way = fill_go ? vway : hway;
  wire [IDX_W+1:0]  dat_adr = fill_go ? {idx, beat} : {idx, wsel};
  wire [63:0]       dat_wd  = fill_go ? mem_fill_data : r_wd;

  always_ff @(posedge clk) begin
    if (dat_we) dat_q[dat_way][dat_adr] <= dat_wd;
    if (fill_go && beat == 2'd3) tag_q[vway][idx] <= ptag;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      beat  <= 2'd0;
      vway  <= 1'b0;
      r_off <= '0;
      r_pfn <= '0;
      r_we  <= 1'b0;
      r_wt  <= 1'b0;
      r_wd  <= '0;
      lru_q <= '0;
      for (int w = 0; w < 2; w++) begin
        val_q[w] <= '0;
        dty_q[w] <= '0;
      end
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          r_off <= req_voff;
          r_pfn <= xl_pfn;
          r_we  <= req_write;
          r_wt  <= req_wthru;
          r_wd  <= req_wdata;
          st    <= S_LOOK;
        end
        S_LOOK: if (hit) begin
          lru_q[idx] <= ~hway;
          if (r_we && !r_wt) dty_q[hway][idx] <= 1'b1;
          st <= (r_we && r_wt) ? S_WT : S_IDLE;
        end else begin
          vway <= lway;
          beat <= 2'd0;
          if (vdirty) st <= S_WB;
          else begin
            val_q[lway][idx] <= 1'b0;
            st <= S_RDREQ;
          end
        end
        S_WB: if (mem_wr_ready) begin
          beat <= beat + 2'd1;
          if (beat == 2'd3) begin
            val_q[vway][idx] <= 1'b0;
            dty_q[vway][idx] <= 1'b0;
            st <= S_RDREQ;
          end
        end
        S_RDREQ: if (mem_rd_ready) begin
          beat <= 2'd0;
          st   <= S_FILL;
        end
        S_FILL: if (mem_fill_valid) begin
          beat <= beat + 2'd1;
          if (beat == 2'd3) begin
            val_q[vway][idx] <= 1'b1;
            dty_q[vway][idx] <= 1'b0;
            st <= S_LOOK;
          end
        end
        S_WT: if (mem_wr_ready) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  p_single_hit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_LOOK) |-> !(hit0 && hit1));
  p_busy_after_accept_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
  p_hit_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (look_hit && !r_we) |-> (resp_valid && !mem_rd_valid && !mem_wr_valid));
  p_wb_store_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (look_hit && r_we && !r_wt) |=> !mem_wr_valid);
  p_victim_flushed_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_valid |-> (!val_q[vway][idx] && !dty_q[vway][idx]));
  p_wt_stays_clean_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (look_hit && r_we && r_wt && !dty_q[hway][idx]) |=> !dty_q[$past(hway)][$past(idx)]);
  p_lru_other_r6: assert property (@(posedge clk) disable iff (!rst_n)
    look_hit |=> (lru_q[$past(idx)] != $past(hway)));
  p_miss_no_resp_r7: assert property (@(posedge clk) disable iff (!rst_n)
    look_miss |-> !resp_valid);
  p_wr_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_valid && !mem_wr_ready) |=> (mem_wr_valid && $stable(mem_wr_addr) && $stable(mem_wr_data)));
endmodule

// File: tb/vipt_dcache_test.sv
`timescale 1ns/1ps
module vipt_dcache_test;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, req_wthru = 1'b0;
  logic [11:0] req_voff = '0;
  logic [63:0] req_wdata = '0;
  logic [2:0]  xl_pfn = '0;
  logic        req_ready, resp_valid;
  logic [63:0] resp_rdata;
  logic        mem_rd_valid, mem_rd_ready = 1'b0;
  logic [14:0] mem_rd_addr;
  logic        mem_fill_valid = 1'b0;
  logic [63:0] mem_fill_data = '0;
  logic        mem_wr_valid, mem_wr_ready = 1'b0;
  logic [14:0] mem_wr_addr;
  logic [63:0] mem_wr_data;

  vipt_dcache #(.SETS(4), .PFN_W(3), .PAGE_BITS(12)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_wthru(req_wthru), .req_voff(req_voff),
    .req_wdata(req_wdata), .xl_pfn(xl_pfn), .resp_valid(resp_valid),
    .resp_rdata(resp_rdata), .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready),
    .mem_rd_addr(mem_rd_addr), .mem_fill_valid(mem_fill_valid),
    .mem_fill_data(mem_fill_data), .mem_wr_valid(mem_wr_valid),
    .mem_wr_ready(mem_wr_ready), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data));

  int checks = 0, errors = 0;
  logic [63:0] bmem [4096];
  logic [63:0] ref_mem [4096];
  int n_rd = 0, n_wr = 0, rd_snap = 0, busy_bad = 0, stab_bad = 0;
  logic [14:0] wlog_a [16];
  logic [63:0] wlog_d [16];
  int fill_left = 0, fill_idx = 0;
  logic [11:0] fill_base = '0;
  bit hold_pend = 0;
  logic [14:0] hold_a;
  logic [63:0] hold_d;

  function automatic logic [63:0] init_word(int a);
    return 64'h9E37_79B9_7F4A_7C15 * (a + 1) ^ 64'h0123_4567;
  endfunction

  function automatic int waddr(int pfn, int off);
    return (pfn << 9) | (off >> 3);
  endfunction

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    mem_wr_ready = ($urandom % 10) < 7;
    mem_rd_ready = ($urandom % 10) < 7;
    if (fill_left > 0 && ($urandom % 4) != 0) begin
      mem_fill_valid = 1'b1;
      mem_fill_data  = bmem[fill_base + 12'(fill_idx)];
      fill_idx++;
      fill_left--;
    end else mem_fill_valid = 1'b0;
    #1;
    if (hold_pend && !(mem_wr_valid && mem_wr_addr == hold_a && mem_wr_data == hold_d)) stab_bad++;
    hold_pend = mem_wr_valid && !mem_wr_ready;
    hold_a = mem_wr_addr;
    hold_d = mem_wr_data;
    if (mem_wr_valid && mem_wr_ready) begin
      bmem[mem_wr_addr[14:3]] = mem_wr_data;
      wlog_a[n_wr % 16] = mem_wr_addr;
      wlog_d[n_wr % 16] = mem_wr_data;
      n_wr++;
    end
    if (mem_rd_valid && mem_rd_ready) begin
      rd_snap   = n_wr;
      fill_base = mem_rd_addr[14:3];
      fill_idx  = 0;
      fill_left = 4;
      n_rd++;
    end
  end

  task automatic access(input bit we, input bit wt, input int pfn, input int off,
                        input logic [63:0] wd, output logic [63:0] rd, output int lat);
    @(negedge clk);
    req_valid = 1'b1; req_write = we; req_wthru = wt;
    req_voff = 12'(off); xl_pfn = 3'(pfn); req_wdata = wd;
    #2;
    while (!req_ready) begin @(negedge clk); #2; end
    @(negedge clk);
    req_valid = 1'b0;
    #2;
    lat = 1;
    while (!resp_valid && lat < 400) begin
      if (req_ready) busy_bad++;
      @(negedge clk); #2;
      lat++;
    end
    rd = resp_rdata;
    if (we) ref_mem[waddr(pfn, off)] = wd;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual %0d expected %0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [63:0] rd;
    int lat, r0, w0;
    void'($urandom(32'd2024));
    for (int i = 0; i < 4096; i++) begin
      bmem[i] = init_word(i);
      ref_mem[i] = init_word(i);
    end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    #2;
    // R10 reset state
    chk(req_ready == 1'b1, "R10 ready after reset", 64'(req_ready), 64'd1);
    chk(!mem_rd_valid && !mem_wr_valid, "R10 no memory request", 64'({mem_rd_valid, mem_wr_valid}), 64'd0);

    // R7 miss refill and replay, R11 busy
    r0 = n_rd;
    access(0, 0, 1, 12'h048, 0, rd, lat);
    chk(n_rd - r0 == 1, "R7 one refill on miss", 64'(n_rd - r0), 64'd1);
    chk(rd == ref_mem[waddr(1, 12'h048)], "R7 replayed load data", rd, ref_mem[waddr(1, 12'h048)]);
    chk(busy_bad == 0, "R11 ready low while busy", 64'(busy_bad), 64'd0);
    // R1 hit latency
    r0 = n_rd;
    access(0, 0, 1, 12'h040, 0, rd, lat);
    chk(lat == 1, "R1 hit latency", 64'(lat), 64'd1);
    chk(n_rd == r0, "R1 no refill on hit", 64'(n_rd - r0), 64'd0);
    chk(rd == ref_mem[waddr(1, 12'h040)], "R1 hit data", rd, ref_mem[waddr(1, 12'h040)]);
    // R2 R3 same offset other frame
    r0 = n_rd; w0 = n_wr;
    access(0, 0, 2, 12'h048, 0, rd, lat);
    chk(n_rd - r0 == 1, "R2 other frame misses", 64'(n_rd - r0), 64'd1);
    chk(rd == ref_mem[waddr(2, 12'h048)], "R3 data from translated frame", rd, ref_mem[waddr(2, 12'h048)]);
    // R6 LRU
    access(0, 0, 1, 12'h040, 0, rd, lat);
    access(0, 0, 3, 12'h040, 0, rd, lat);
    r0 = n_rd;
    access(0, 0, 1, 12'h050, 0, rd, lat);
    chk(n_rd == r0, "R6 recently used way kept", 64'(n_rd - r0), 64'd0);
    access(0, 0, 2, 12'h040, 0, rd, lat);
    chk(n_rd - r0 == 1, "R6 other way evicted", 64'(n_rd - r0), 64'd1);
    chk(n_wr == w0, "R8 clean evictions write nothing", 64'(n_wr - w0), 64'd0);

    // R4 write-back
    w0 = n_wr;
    access(1, 0, 4, 12'h028, 64'hD1D1_0000_0000_0001, rd, lat);
    access(1, 0, 4, 12'h030, 64'hD2D2_0000_0000_0002, rd, lat);
    chk(lat == 1, "R4 store hit latency", 64'(lat), 64'd1);
    access(0, 0, 5, 12'h020, 0, rd, lat);
    chk(n_wr == w0, "R4 write-back stores stay in cache", 64'(n_wr - w0), 64'd0);
    access(0, 0, 6, 12'h020, 0, rd, lat);
    chk(n_wr - w0 == 4, "R4 dirty eviction writes four beats", 64'(n_wr - w0), 64'd4);
    chk(rd_snap == w0 + 4, "R4 writeback precedes refill", 64'(rd_snap), 64'(w0 + 4));
    for (int k = 0; k < 4; k++)
      chk(wlog_a[(w0 + k) % 16] == 15'(16'h4020 + 8 * k), "R4 writeback address order",
          64'(wlog_a[(w0 + k) % 16]), 64'(16'h4020 + 8 * k));
    chk(wlog_d[(w0 + 1) % 16] == 64'hD1D1_0000_0000_0001, "R4 written back data", wlog_d[(w0 + 1) % 16], 64'hD1D1_0000_0000_0001);
    access(0, 0, 4, 12'h030, 0, rd, lat);
    chk(rd == 64'hD2D2_0000_0000_0002, "R4 reload after writeback", rd, 64'hD2D2_0000_0000_0002);

    // R5 write-through
    access(0, 1, 1, 12'h060, 0, rd, lat);
    w0 = n_wr;
    access(1, 1, 1, 12'h070, 64'hD3D3_0000_0000_0003, rd, lat);
    chk(n_wr - w0 == 1, "R5 one word forwarded", 64'(n_wr - w0), 64'd1);
    chk(wlog_a[w0 % 16] == 15'h1070, "R5 forwarded address", 64'(wlog_a[w0 % 16]), 64'h1070);
    chk(wlog_d[w0 % 16] == 64'hD3D3_0000_0000_0003, "R5 forwarded data", wlog_d[w0 % 16], 64'hD3D3_0000_0000_0003);
    r0 = n_rd;
    access(0, 1, 1, 12'h070, 0, rd, lat);
    chk(rd == 64'hD3D3_0000_0000_0003 && n_rd == r0, "R5 line updated on hit", rd, 64'hD3D3_0000_0000_0003);
    w0 = n_wr;
    access(0, 0, 2, 12'h060, 0, rd, lat);
    access(0, 0, 3, 12'h060, 0, rd, lat);
    chk(n_wr == w0, "R5 write-through line evicts clean", 64'(n_wr - w0), 64'd0);

    // random mix
    for (int i = 0; i < 1500; i++) begin
      int p, o;
      bit we;
      logic [63:0] d;
      p  = $urandom % 8;
      o  = ($urandom % 4096) & 12'hFF8;
      we = ($urandom % 3) == 0;
      d  = {$urandom, $urandom};
      if (i % 100 == 0) o = 12'h040;
      access(we, p[0], p, o, d, rd, lat);
      if (!we) chk(rd == ref_mem[waddr(p, o)], "R7 random load data", rd, ref_mem[waddr(p, o)]);
    end
    chk(busy_bad == 0, "R11 ready low while busy (random)", 64'(busy_bad), 64'd0);
    chk(stab_bad == 0, "R9 write port held while stalled", 64'(stab_bad), 64'd0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule